// File: doc/BRIEF.md
# Serial Frame Gap Timing Supervisor

This block sits next to a byte-oriented serial receiver on a half-duplex multi-drop bus. The receiver gives it a one-cycle strobe for every character it takes off the line. The supervisor has no view of the characters themselves. It works only from their timing, and it uses a single reloadable down-counter to find the silences that separate frames. A sticky "character seen" flag records whether the line was active during a window.

Around that timer the block runs a cyclic bus schedule, with one timer window per phase:

- **LISTEN**: waits for traffic for at most the listen window.
- **RECV**: collects characters until the line goes quiet for one gap window.
- **CONFIRM**: used only in fixed-length mode. It waits a confirmation window that is slightly longer than the gap.
- **QUIET**: after a frame, the line must stay silent for the quiet window.
- **WAIT**: waits out the rest of the bus cycle.

The named transitions are:

- *start-frame*: LISTEN or WAIT to RECV (or to CONFIRM when the expected length is 1), taken on a character.
- *restart-gap*: RECV to RECV, or CONFIRM to RECV, taken on a character.
- *count-reached*: RECV to CONFIRM.
- *gap-end*: RECV to QUIET.
- *confirm-end*: CONFIRM to QUIET.
- *quiet-retry*: QUIET to QUIET, taken when the expiring window saw traffic.
- *quiet-done*: QUIET to WAIT.
- *wait-done*: WAIT to LISTEN.
- *no-traffic*: LISTEN to LISTEN.

Events leave on four single-cycle pulse outputs. Every duration is set in microseconds and converted to clock cycles from a clock-frequency parameter in kHz, using cycles = kHz × µs / 1000. The defaults are a 1000 µs gap, a 30000 µs listen window, an 8000 µs quiet window and a 22000 µs wait window. The confirmation window is always the gap plus one fifth of the gap. A 500 µs gap therefore gives a 600 µs confirmation window.

Top module: `frame_gap_supervisor`

## Requirements
- R1: A synchronous active-high reset clears all four outputs and the seen flag and places the block in LISTEN. With no traffic, the first `timeout` pulse is visible in the cycle following the LISTEN_C-th rising edge after the last reset edge.
- R2: In LISTEN, a window that expires with no character pulses `timeout` once and starts a new listen window. Consecutive timeouts are therefore LISTEN_C cycles apart.
- R3: Every character sampled in RECV restarts the gap window. When fixed-length mode is off, `frame_end` pulses GAP_C cycles after the edge that sampled the last character of the frame.
- R4: After a frame ends, a QUIET window of QUIET_C cycles runs with the flag cleared. The first character inside the window pulses `proto_err` one cycle after it is sampled, and later characters in the same window give no further pulse. A window that saw traffic is followed by a fresh QUIET window.
- R5: A silent QUIET window is followed by a WAIT window of WAIT_C cycles. The end of the WAIT window leads to LISTEN without a `timeout`. A character during WAIT starts a frame without `proto_err`.
- R6: When `fix_en` is 1 and the byte count of a frame reaches `fix_len` (which must be 1 or more), the confirmation window CONFIRM_C starts. If it expires silently, `frame_ok` pulses CONFIRM_C cycles after the last character, and `frame_end` does not pulse for that frame.
- R7: In fixed-length mode, a character that arrives inside the confirmation window invalidates the frame. The frame then ends with `frame_end` at the gap after its last character, and no `frame_ok` is given.
- R8: In fixed-length mode, a frame shorter than `fix_len` ends with `frame_end` at the gap, and no `frame_ok` is given.
- R9: Each output is a single-cycle pulse, and at most one of the four outputs is high in any cycle.
- R10: A character sampled in the same cycle as a timer expiry is handled as a character, and the expiry is not reported in that cycle. In RECV the gap therefore restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_stb | input | 1 | One-cycle strobe for each received character |
| fix_en | input | 1 | 1 selects fixed-length frame mode |
| fix_len | input | LEN_W | Expected byte count in fixed-length mode (1 or more) |
| frame_end | output | 1 | Pulse: the frame was closed by the gap |
| frame_ok | output | 1 | Pulse: a fixed-length frame was confirmed |
| timeout | output | 1 | Pulse: the listen window passed with no traffic |
| proto_err | output | 1 | Pulse: a character arrived in the quiet window |

## Verification
The collision that matters is a character strobe landing in exactly the cycle in which the timer expires. In RECV this is the end of the gap; in QUIET it is the end of the quiet window. A directed case places the second character of a frame exactly GAP_C cycles after the first. It then checks two things: that no `frame_end` appears at that point, and that the gap measured from the second character is GAP_C. The randomized traffic also uses spacings of GAP_C − 1, GAP_C and GAP_C + 1 around the gap. Every cycle, a bench model that steps the phase schedule from the requirements judges all four pulse outputs.

// File: rtl/fgs_pkg.sv
package fgs_pkg;

    typedef enum logic [2:0] {
        ST_LISTEN,
        ST_RECV,
        ST_CONFIRM,
        ST_QUIET,
        ST_WAIT
    } phase_e;

    // microseconds to clock cycles for a clock given in kHz
    function automatic longint us_to_cycles(longint khz, longint us);
        return (khz * us) / 1000;
    endfunction

    function automatic longint lmax(longint a, longint b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fgs_timer.sv
module fgs_timer #(
    parameter int     TW      = 8,
    parameter longint RST_CYC = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [TW-1:0] val,
    output logic          exp
);

    logic [TW-1:0] remain;

    // a load of N makes exp visible N-1 edges later, so the FSM acts on the Nth edge
    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= TW'(RST_CYC - 1);
        end else if (ld) begin
            remain <= val - TW'(1);
        end else if (remain != '0) begin
            remain <= remain - TW'(1);
        end
    end

    assign exp = (remain == '0);

    // the counter parks at zero until it is reloaded
    p_park_r10: assert property (@(posedge clk) disable iff (rst)
        (exp && !ld) |=> exp);

endmodule

// File: rtl/fgs_byte_counter.sv
module fgs_byte_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          first,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (first) begin
            cnt <= CW'(1);
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + CW'(1);
        end
    end

    // within a frame the count never falls, so an overrun byte cannot re-match the length
    p_cnt_mono_r7: assert property (@(posedge clk) disable iff (rst)
        !first |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/frame_gap_supervisor.sv
module frame_gap_supervisor
    import fgs_pkg::*;
#(
    parameter longint CLK_KHZ   = 200_000,
    parameter longint GAP_US    = 1000,
    parameter longint LISTEN_US = 30000,
    parameter longint QUIET_US  = 8000,
    parameter longint WAIT_US   = 22000,
    parameter int     LEN_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_stb,
    input  logic             fix_en,
    input  logic [LEN_W-1:0] fix_len,
    output logic             frame_end,
    output logic             frame_ok,
    output logic             timeout,
    output logic             proto_err
);

    localparam longint CONFIRM_US = GAP_US + GAP_US / 5;
    localparam longint LISTEN_C   = us_to_cycles(CLK_KHZ, LISTEN_US);
    localparam longint GAP_C      = us_to_cycles(CLK_KHZ, GAP_US);
    localparam longint CONFIRM_C  = us_to_cycles(CLK_KHZ, CONFIRM_US);
    localparam longint QUIET_C    = us_to_cycles(CLK_KHZ, QUIET_US);
    localparam longint WAIT_C     = us_to_cycles(CLK_KHZ, WAIT_US);
    localparam longint MAX_C      = lmax(lmax(LISTEN_C, WAIT_C), lmax(QUIET_C, CONFIRM_C));
    localparam int     TW         = $clog2(MAX_C + 1);
    localparam int     CW         = LEN_W + 1;

    phase_e         st, st_nxt;
    logic           seen, seen_clr;
    logic           tmr_ld, tmr_exp;
    logic [TW-1:0]  tmr_val;
    logic           cnt_first, cnt_inc;
    logic [CW-1:0]  cnt;
    logic [CW:0]    cnt_after;
    logic           hit;
    logic           ev_end, ev_ok, ev_to, ev_err;

    fgs_timer #(.TW(TW), .RST_CYC(LISTEN_C)) u_tmr (
        .clk (clk),
        .rst (rst),
        .ld  (tmr_ld),
        .val (tmr_val),
        .exp (tmr_exp)
    );

    fgs_byte_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .first (cnt_first),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    // byte count this character will produce, compared against the expected length
    always_comb begin
        if (st == ST_LISTEN || st == ST_WAIT) begin
            cnt_after = (CW+1)'(1);
        end else begin
            cnt_after = {1'b0, cnt} + (CW+1)'(1);
        end
        hit = fix_en && (cnt_after == {2'b00, fix_len});
    end

    // next phase, timer load and events; a character always outranks an expiry
    always_comb begin
        st_nxt    = st;
        tmr_ld    = 1'b0;
        tmr_val   = TW'(LISTEN_C);
        seen_clr  = 1'b0;
        cnt_first = 1'b0;
        cnt_inc   = 1'b0;
        ev_end    = 1'b0;
        ev_ok     = 1'b0;
        ev_to     = 1'b0;
        ev_err    = 1'b0;
        unique case (st)
            ST_LISTEN, ST_WAIT: begin
                if (rx_stb) begin                       // start-frame
                    cnt_first = 1'b1;
                    tmr_ld    = 1'b1;
                    if (hit) begin
                        st_nxt  = ST_CONFIRM;
                        tmr_val = TW'(CONFIRM_C);
                    end else begin
                        st_nxt  = ST_RECV;
                        tmr_val = TW'(GAP_C);
                    end
                end else if (tmr_exp) begin             // no-traffic / wait-done
                    st_nxt   = ST_LISTEN;
                    tmr_ld   = 1'b1;
                    tmr_val  = TW'(LISTEN_C);
                    seen_clr = 1'b1;
                    ev_to    = (st == ST_LISTEN);
                end
            end
            ST_RECV: begin
                if (rx_stb) begin                       // restart-gap / count-reached
                    cnt_inc = 1'b1;
                    tmr_ld  = 1'b1;
                    if (hit) begin
                        st_nxt  = ST_CONFIRM;
                        tmr_val = TW'(CONFIRM_C);
                    end else begin
                        tmr_val = TW'(GAP_C);
                    end
                end else if (tmr_exp) begin             // gap-end
                    st_nxt   = ST_QUIET;
                    tmr_ld   = 1'b1;
                    tmr_val  = TW'(QUIET_C);
                    seen_clr = 1'b1;
                    ev_end   = 1'b1;
                end
            end
            ST_CONFIRM: begin
                if (rx_stb) begin                       // restart-gap: frame overrun
                    cnt_inc = 1'b1;
                    st_nxt  = ST_RECV;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(GAP_C);
                end else if (tmr_exp) begin             // confirm-end
                    st_nxt   = ST_QUIET;
                    tmr_ld   = 1'b1;
                    tmr_val  = TW'(QUIET_C);
                    seen_clr = 1'b1;
                    ev_ok    = 1'b1;
                end
            end
            ST_QUIET: begin
                if (rx_stb) begin
                    ev_err = !seen;
                end else if (tmr_exp) begin
                    tmr_ld   = 1'b1;
                    seen_clr = 1'b1;
                    if (seen) begin                     // quiet-retry
                        tmr_val = TW'(QUIET_C);
                    end else begin                      // quiet-done
                        st_nxt  = ST_WAIT;
                        tmr_val = TW'(WAIT_C);
                    end
                end
            end
            default: begin
                st_nxt = ST_LISTEN;
            end
        endcase
    end

    // phase register and sticky character flag
    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_LISTEN;
            seen <= 1'b0;
        end else begin
            st <= st_nxt;
            if (seen_clr) begin
                seen <= 1'b0;
            end else if (rx_stb) begin
                seen <= 1'b1;
            end
        end
    end

    // registered event pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_end <= 1'b0;
            frame_ok  <= 1'b0;
            timeout   <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            frame_end <= ev_end;
            frame_ok  <= ev_ok;
            timeout   <= ev_to;
            proto_err <= ev_err;
        end
    end

    p_one_event_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_end, frame_ok, timeout, proto_err}));

    p_end_single_r9: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

    p_ok_single_r6: assert property (@(posedge clk) disable iff (rst)
        frame_ok |=> !frame_ok);

    p_char_wins_r10: assert property (@(posedge clk) disable iff (rst)
        rx_stb |=> !(frame_end || frame_ok || timeout));

    p_listen_clean_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LISTEN) |-> !seen);

    p_err_in_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(st) == ST_QUIET && $past(rx_stb)));

    p_expiry_reload_r2: assert property (@(posedge clk) disable iff (rst)
        (tmr_exp && !rx_stb) |-> tmr_ld);

endmodule

// File: tb/sim_frame_gap_supervisor.sv
`timescale 1ns/1ps
module sim_frame_gap_supervisor;

    localparam int LEN_W = 8;
    localparam int GAP   = 20;
    localparam int CONF  = 24;
    localparam int LIS   = 300;
    localparam int QUI   = 80;
    localparam int WAI   = 220;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_stb = 1'b0;
    logic             fix_en = 1'b0;
    logic [LEN_W-1:0] fix_len = 8'd4;
    logic             frame_end, frame_ok, timeout, proto_err;

    int checks = 0;
    int fails  = 0;

    frame_gap_supervisor #(
        .CLK_KHZ(1000), .GAP_US(GAP), .LISTEN_US(LIS),
        .QUIET_US(QUI), .WAIT_US(WAI), .LEN_W(LEN_W)
    ) u0 (
        .clk(clk), .rst(rst), .rx_stb(rx_stb), .fix_en(fix_en), .fix_len(fix_len),
        .frame_end(frame_end), .frame_ok(frame_ok), .timeout(timeout), .proto_err(proto_err)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference schedule stepped from the requirements
    int pcyc = 0;
    int m_st = 0, m_rem = LIS, m_cnt = 0;
    bit m_seen = 0;
    bit e_end = 0, e_ok = 0, e_to = 0, e_err = 0;
    int t_stb = 0;

    always @(posedge clk) begin
        pcyc++;
        if (rx_stb) t_stb = pcyc;
        e_end = 0; e_ok = 0; e_to = 0; e_err = 0;
        if (rst) begin
            m_st = 0; m_rem = LIS; m_seen = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0, 4: if (rx_stb) begin
                          m_seen = 1; m_cnt = 1;
                          if (fix_en && fix_len == 1) begin m_st = 2; m_rem = CONF; end
                          else begin m_st = 1; m_rem = GAP; end
                      end else if (m_rem == 1) begin
                          e_to = (m_st == 0); m_st = 0; m_rem = LIS; m_seen = 0;
                      end else m_rem--;
                1:    if (rx_stb) begin
                          m_seen = 1; m_cnt++;
                          if (fix_en && m_cnt == int'(fix_len)) begin m_st = 2; m_rem = CONF; end
                          else m_rem = GAP;
                      end else if (m_rem == 1) begin
                          e_end = 1; m_st = 3; m_rem = QUI; m_seen = 0;
                      end else m_rem--;
                2:    if (rx_stb) begin
                          m_seen = 1; m_cnt++; m_st = 1; m_rem = GAP;
                      end else if (m_rem == 1) begin
                          e_ok = 1; m_st = 3; m_rem = QUI; m_seen = 0;
                      end else m_rem--;
                default: if (rx_stb) begin
                          e_err = !m_seen; m_seen = 1;
                          if (m_rem > 1) m_rem--;
                      end else if (m_rem == 1) begin
                          if (m_seen) m_rem = QUI;
                          else begin m_st = 4; m_rem = WAI; end
                          m_seen = 0;
                      end else m_rem--;
            endcase
        end
    end

    // observed pulses, time stamps and per-cycle comparison
    int n_end = 0, n_ok = 0, n_to = 0, n_err = 0;
    int t_end = 0, t_ok = 0, t_to = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_end) begin n_end++; t_end = pcyc; end
            if (frame_ok)  begin n_ok++;  t_ok  = pcyc; end
            if (timeout)   begin n_to++;  t_to  = pcyc; end
            if (proto_err) n_err++;
            chk(frame_end == e_end, "R3", "frame_end", frame_end, e_end);
            chk(frame_ok  == e_ok,  "R6", "frame_ok",  frame_ok,  e_ok);
            chk(timeout   == e_to,  "R2", "timeout",   timeout,   e_to);
            chk(proto_err == e_err, "R4", "proto_err", proto_err, e_err);
            chk($countones({frame_end, frame_ok, timeout, proto_err}) <= 1, "R9",
                "pulses high", $countones({frame_end, frame_ok, timeout, proto_err}), 1);
        end
    end

    int t_rel = 0;
    task automatic do_reset();
        @(negedge clk) rst = 1; rx_stb = 0;
        repeat (3) @(negedge clk);
        chk({frame_end, frame_ok, timeout, proto_err} == 4'b0, "R1", "outputs in reset",
            {frame_end, frame_ok, timeout, proto_err}, 0);
        rst = 0; t_rel = pcyc;
        n_end = 0; n_ok = 0; n_to = 0; n_err = 0;
    endtask

    task automatic strobe();
        @(negedge clk) rx_stb = 1;
        @(negedge clk) rx_stb = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        int w = 0;
        while (w < 150000) begin @(posedge clk); w++; end
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected 0 cycles", w);
        finish_up();
    end

    initial begin
        int t1;
        // R1 / R2: timeout cadence from reset
        do_reset();
        while (n_to < 1) @(negedge clk);
        chk(t_to - t_rel == LIS, "R1", "first timeout delay", t_to - t_rel, LIS);
        t1 = t_to;
        while (n_to < 2) @(negedge clk);
        chk(t_to - t1 == LIS, "R2", "timeout spacing", t_to - t1, LIS);

        // R3: variable-length frame, three characters inside the gap
        do_reset();
        strobe(); idle(8); strobe(); idle(8); strobe();
        t1 = t_stb;
        idle(GAP + 2);
        chk(n_end == 1, "R3", "frame_end count", n_end, 1);
        chk(t_end - t1 == GAP, "R3", "gap delay", t_end - t1, GAP);

        // R4: two characters inside the quiet window, one error
        idle(10); strobe(); idle(5); strobe();
        idle(3);
        chk(n_err == 1, "R4", "proto_err count", n_err, 1);
        // retry window then wait: nothing more
        idle(2 * QUI + WAI + 10);
        chk(n_to == 0, "R5", "timeout at wait end", n_to, 0);

        // R5: character in the wait window starts a frame
        do_reset();
        strobe(); idle(GAP + QUI + 50); strobe();
        idle(GAP + 3);
        chk(n_end == 2, "R5", "frame from wait", n_end, 2);
        chk(n_err == 0, "R5", "no error in wait", n_err, 0);

        // R6: exact fixed length confirmed
        do_reset();
        fix_en = 1; fix_len = 8'd4;
        repeat (4) begin strobe(); idle(4); end
        t1 = t_stb;
        idle(CONF + 2);
        chk(n_ok == 1 && n_end == 0, "R6", "ok/end", n_ok * 10 + n_end, 10);
        chk(t_ok - t1 == CONF, "R6", "confirm delay", t_ok - t1, CONF);

        // R7: one byte too many
        do_reset();
        repeat (5) begin strobe(); idle(4); end
        t1 = t_stb;
        idle(CONF + 4);
        chk(n_ok == 0 && n_end == 1, "R7", "ok/end", n_ok * 10 + n_end, 1);
        chk(t_end - t1 == GAP, "R7", "gap delay", t_end - t1, GAP);

        // R8: short frame
        do_reset();
        strobe(); idle(4); strobe();
        idle(CONF + 4);
        chk(n_ok == 0 && n_end == 1, "R8", "ok/end", n_ok * 10 + n_end, 1);

        // R10: second character on the expiry edge
        do_reset();
        fix_en = 0;
        strobe(); t1 = t_stb; idle(GAP - 2); strobe();
        chk(t_stb - t1 == GAP, "R10", "collision spacing", t_stb - t1, GAP);
        chk(n_end == 0, "R10", "no end at collision", n_end, 0);
        t1 = t_stb;
        idle(GAP + 2);
        chk(n_end == 1 && t_end - t1 == GAP, "R10", "gap after collision", t_end - t1, GAP);

        // random traffic, judged every cycle by the model
        do_reset();
        void'($urandom(32'd20240611));
        for (int b = 0; b < 60; b++) begin
            fix_en  = $urandom % 2;
            fix_len = LEN_W'(1 + $urandom % 5);
            for (int c = 0; c < 1 + int'($urandom % 7); c++) begin
                strobe();
                case ($urandom % 4)
                    0: idle(GAP - 3);
                    1: idle(GAP - 2);
                    2: idle(GAP - 1);
                    default: idle($urandom % GAP);
                endcase
            end
            idle($urandom % 400);
        end
        idle(LIS + 10);
        finish_up();
    end

endmodule